// File: doc/BRIEF.md
# Stack Frame Address Sequencer

This block is the memory-operand and stack unit of a 32-bit register-memory processor model. Each request carries a command code, an addressing-mode code, a base value, an index value, a scale selector and a signed constant. The block forms the effective address, or the operand itself for the modes that do not touch memory. It drives one synchronous word port with a read latency of one cycle. It also holds the stack pointer and the frame pointer. Commands that work on a frame are broken into an ordered series of single-cycle steps. Each step either moves a pointer or makes one memory access.

Command codes on `cmd_op`: 0 load, 1 store, 2 push, 3 pop, 4 enter, 5 leave, 6 call, 7 ret. Mode codes on `cmd_mode`: 0 register only, 1 immediate, 2 base plus constant, 3 base plus index, 4 base plus scaled index, 5 base plus scaled index plus constant. Codes 6 and 7 act as code 0. The scale factor is 2 to the power `cmd_scale`, which gives 1, 2, 4 or 8. The push and store data, and the return address of a call, come from `cmd_data`. The frame size of an enter and the target of a call come from `cmd_imm`.

The controller is a state machine with these states. S_IDLE waits for a command. S_MEM_RD issues a load and S_MEM_RDW returns its data. S_MEM_WR performs a store. S_FWD returns a register or immediate operand. S_FAULT reports a misaligned address. S_SP_DEC lowers the stack pointer and S_PUSH_WR writes the pushed word. S_FP_SET copies the stack pointer into the frame pointer. S_SP_SUB subtracts the frame size. S_SP_FROM_FP copies the frame pointer into the stack pointer. S_POP_RD reads the top of the stack. S_POP_WB raises the stack pointer and delivers the popped word. S_REDIRECT issues the call target.

The transitions from S_IDLE depend on the command:
- A load goes to S_FWD, S_FAULT or S_MEM_RD.
- A store goes to S_MEM_WR or S_FAULT, or stays in S_IDLE.
- Push, enter and call go to S_SP_DEC.
- Pop and ret go to S_POP_RD.
- Leave goes to S_SP_FROM_FP.

The other transitions are fixed:
- S_MEM_RD goes to S_MEM_RDW, S_SP_DEC to S_PUSH_WR, S_FP_SET to S_SP_SUB, S_SP_FROM_FP to S_POP_RD, and S_POP_RD to S_POP_WB.
- S_PUSH_WR goes to S_FP_SET for an enter, to S_REDIRECT for a call, and to S_IDLE otherwise.
- Every other state returns to S_IDLE.

Top module: `stack_frame_seq`

## Requirements
- R1: For mode 5 the address is base + (index << cmd_scale) + constant. Mode 4 omits the constant, mode 3 adds index to base with no scaling, and mode 2 adds the signed constant to base. The result of a load (op 0) is the word stored at that address.
- R2: A load in mode 0 (and in modes 6 and 7) returns the base value, and a load in mode 1 returns the constant. Neither makes a memory access.
- R3: The memory port has a read latency of one cycle. A load result is valid on `res_valid` in the cycle after its read request.
- R4: A load or store (op 1) whose address has nonzero low two bits makes no access. It pulses `align_err` for one cycle and leaves both pointers unchanged. Every access on the port is word aligned.
- R5: A store in mode 0 or 1 is ignored: no memory word changes.
- R6: A push (op 2) first lowers the stack pointer by 4, then writes `cmd_data` at the new stack-pointer address.
- R7: A pop (op 3) first reads the word at the stack pointer, then raises the stack pointer by 4 and returns the word on `res_data`.
- R8: An enter (op 4) pushes the frame pointer, copies the stack pointer into the frame pointer, and then subtracts the frame size with its low two bits cleared, in that order.
- R9: A leave (op 5) copies the frame pointer into the stack pointer, then pops a word into the frame pointer with its low two bits cleared.
- R10: A call (op 6) pushes `cmd_data` as the return address, then pulses `redirect_valid` with `redirect_pc` equal to `cmd_imm`.
- R11: A ret (op 7) pops a word, pulses `redirect_valid` with that word, and leaves the stack pointer 4 higher.
- R12: A command is taken only when `busy` is low. `busy` stays high until the last step of a command completes. A request made while `busy` is high is dropped.
- R13: Reset, even in the middle of a command, sets both pointers to the aligned top-of-stack parameter and clears `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Command code |
| cmd_mode | input | 3 | Addressing-mode code |
| cmd_base | input | 32 | Base register value |
| cmd_index | input | 32 | Index register value |
| cmd_scale | input | 2 | Index shift, 0 to 3 |
| cmd_imm | input | 32 | Signed constant, frame size or call target |
| cmd_data | input | 32 | Store or push data, or call return address |
| busy | output | 1 | Command in progress |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write enable |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| res_valid | output | 1 | Load or pop result valid |
| res_data | output | 32 | Load or pop result |
| redirect_valid | output | 1 | Next program counter valid |
| redirect_pc | output | 32 | Next program counter |
| align_err | output | 1 | Misaligned address pulse |
| sp_out | output | 32 | Stack pointer |
| fp_out | output | 32 | Frame pointer |

## Verification
A new request and the final step of a composite command can fall in the same cycle. In that cycle `busy` is still high while the last pointer update or redirect retires. The bench raises `cmd_valid` exactly in the final busy cycle of an enter. It expects the request to be dropped: the stack pointer is judged to end at the enter's value, and `busy` is judged to stay low afterwards. In a second case a pop is requested during a push. The bench judges that only the push took effect and that a later explicit pop returns the pushed word.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_ENTER = 3'd4,
        OP_LEAVE = 3'd5,
        OP_CALL  = 3'd6,
        OP_RET   = 3'd7
    } sfs_op_e;

    typedef enum logic [2:0] {
        AM_REG   = 3'd0,
        AM_IMM   = 3'd1,
        AM_BDISP = 3'd2,
        AM_BIDX  = 3'd3,
        AM_BSIDX = 3'd4,
        AM_FULL  = 3'd5,
        AM_RSV6  = 3'd6,
        AM_RSV7  = 3'd7
    } sfs_mode_e;

    typedef enum logic [2:0] {
        SP_HOLD    = 3'd0,
        SP_DEC     = 3'd1,
        SP_INC     = 3'd2,
        SP_SUB     = 3'd3,
        SP_FROM_FP = 3'd4
    } sp_act_e;

    typedef enum logic [1:0] {
        FP_HOLD    = 2'd0,
        FP_FROM_SP = 2'd1,
        FP_LOAD    = 2'd2
    } fp_act_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/sfs_agen.sv
module sfs_agen
    import sfs_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned SW = 2
) (
    input  sfs_mode_e         mode_i,
    input  logic [DW-1:0]     base_i,
    input  logic [DW-1:0]     index_i,
    input  logic [SW-1:0]     scale_i,
    input  logic [DW-1:0]     imm_i,
    output logic [DW-1:0]     ea_o,
    output logic [DW-1:0]     operand_o,
    output logic              is_mem_o,
    output logic              misaligned_o
);

    localparam int unsigned LSB_W = $clog2(WORD_BYTES);

    logic [DW-1:0] scaled;

    always_comb begin
        scaled    = index_i << scale_i;
        ea_o      = base_i;
        operand_o = base_i;
        is_mem_o  = 1'b1;
        unique case (mode_i)
            AM_REG, AM_RSV6, AM_RSV7: begin
                is_mem_o  = 1'b0;
                operand_o = base_i;
            end
            AM_IMM: begin
                is_mem_o  = 1'b0;
                operand_o = imm_i;
            end
            AM_BDISP: ea_o = base_i + imm_i;
            AM_BIDX:  ea_o = base_i + index_i;
            AM_BSIDX: ea_o = base_i + scaled;
            AM_FULL:  ea_o = base_i + scaled + imm_i;
        endcase
        misaligned_o = is_mem_o && (ea_o[LSB_W-1:0] != '0);
    end

endmodule

// File: rtl/sfs_ptr_regs.sv
module sfs_ptr_regs
    import sfs_pkg::*;
#(
    parameter int unsigned   DW  = 32,
    parameter logic [DW-1:0] TOS = 32'h0000_0400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  sp_act_e       sp_act_i,
    input  fp_act_e       fp_act_i,
    input  logic [DW-1:0] frame_i,
    input  logic [DW-1:0] load_i,
    output logic [DW-1:0] sp_o,
    output logic [DW-1:0] fp_o
);

    localparam logic [DW-1:0] STEP     = DW'(WORD_BYTES);
    localparam logic [DW-1:0] LOW_MASK = DW'(WORD_BYTES - 1);
    localparam logic [DW-1:0] TOS_AL   = TOS & ~LOW_MASK;

    logic [DW-1:0] sp_q, fp_q, sp_d, fp_d;

    always_comb begin
        sp_d = sp_q;
        unique case (sp_act_i)
            SP_HOLD:    sp_d = sp_q;
            SP_DEC:     sp_d = sp_q - STEP;
            SP_INC:     sp_d = sp_q + STEP;
            SP_SUB:     sp_d = sp_q - (frame_i & ~LOW_MASK);
            SP_FROM_FP: sp_d = fp_q;
            default:    sp_d = sp_q;
        endcase
        fp_d = fp_q;
        unique case (fp_act_i)
            FP_HOLD:    fp_d = fp_q;
            FP_FROM_SP: fp_d = sp_q;
            FP_LOAD:    fp_d = load_i & ~LOW_MASK;
            default:    fp_d = fp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= TOS_AL;
            fp_q <= TOS_AL;
        end else begin
            sp_q <= sp_d;
            fp_q <= fp_d;
        end
    end

    assign sp_o = sp_q;
    assign fp_o = fp_q;

    // R8, R9: pointers never leave word alignment
    p_sp_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sp_q[1:0] == 2'b00);
    p_fp_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fp_q[1:0] == 2'b00);
    // R13: the first cycle after reset starts from the top of stack
    p_reset_tos_r13: assert property (@(posedge clk)
        !rst_n |=> (sp_q == TOS_AL && fp_q == TOS_AL));

endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
    import sfs_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid_i,
    input  sfs_op_e       op_i,
    input  logic [DW-1:0] ea_i,
    input  logic [DW-1:0] operand_i,
    input  logic          is_mem_i,
    input  logic          misaligned_i,
    input  logic [DW-1:0] imm_i,
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] sp_i,
    input  logic [DW-1:0] fp_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [DW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    output logic          res_valid_o,
    output logic [DW-1:0] res_data_o,
    output logic          redirect_valid_o,
    output logic [DW-1:0] redirect_pc_o,
    output logic          align_err_o,
    output sp_act_e       sp_act_o,
    output fp_act_e       fp_act_o,
    output logic [DW-1:0] frame_o,
    output logic [DW-1:0] fp_load_o
);

    localparam logic [DW-1:0] STEP = DW'(WORD_BYTES);

    typedef enum logic [3:0] {
        S_IDLE, S_MEM_RD, S_MEM_RDW, S_MEM_WR, S_FWD, S_FAULT,
        S_SP_DEC, S_PUSH_WR, S_FP_SET, S_SP_SUB,
        S_SP_FROM_FP, S_POP_RD, S_POP_WB, S_REDIRECT
    } state_e;

    state_e        state_q, state_d;
    sfs_op_e       op_q;
    logic [DW-1:0] ea_q, val_q, imm_q, data_q;
    logic          accept;

    assign accept = cmd_valid_i && (state_q == S_IDLE);

    // state register and command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_LOAD;
            ea_q    <= '0;
            val_q   <= '0;
            imm_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q   <= op_i;
                ea_q   <= ea_i;
                val_q  <= operand_i;
                imm_q  <= imm_i;
                data_q <= data_i;
            end
        end
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid_i) begin
                    unique case (op_i)
                        OP_LOAD:
                            state_d = !is_mem_i    ? S_FWD   :
                                      misaligned_i ? S_FAULT : S_MEM_RD;
                        OP_STORE:
                            state_d = !is_mem_i    ? S_IDLE  :
                                      misaligned_i ? S_FAULT : S_MEM_WR;
                        OP_PUSH, OP_ENTER, OP_CALL: state_d = S_SP_DEC;
                        OP_POP, OP_RET:             state_d = S_POP_RD;
                        OP_LEAVE:                   state_d = S_SP_FROM_FP;
                    endcase
                end
            end
            S_MEM_RD:     state_d = S_MEM_RDW;
            S_SP_DEC:     state_d = S_PUSH_WR;
            S_PUSH_WR: begin
                if (op_q == OP_ENTER)     state_d = S_FP_SET;
                else if (op_q == OP_CALL) state_d = S_REDIRECT;
                else                      state_d = S_IDLE;
            end
            S_FP_SET:     state_d = S_SP_SUB;
            S_SP_FROM_FP: state_d = S_POP_RD;
            S_POP_RD:     state_d = S_POP_WB;
            S_MEM_RDW, S_MEM_WR, S_FWD, S_FAULT,
            S_SP_SUB, S_POP_WB, S_REDIRECT:
                          state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    // outputs per state
    always_comb begin
        busy_o           = (state_q != S_IDLE);
        mem_req_o        = 1'b0;
        mem_we_o         = 1'b0;
        mem_addr_o       = ea_q;
        mem_wdata_o      = '0;
        res_valid_o      = 1'b0;
        res_data_o       = '0;
        redirect_valid_o = 1'b0;
        redirect_pc_o    = '0;
        align_err_o      = 1'b0;
        sp_act_o         = SP_HOLD;
        fp_act_o         = FP_HOLD;
        frame_o          = imm_q;
        fp_load_o        = mem_rdata_i;
        unique case (state_q)
            S_IDLE: ;
            S_MEM_RD: mem_req_o = 1'b1;
            S_MEM_RDW: begin
                res_valid_o = 1'b1;
                res_data_o  = mem_rdata_i;
            end
            S_MEM_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_wdata_o = data_q;
            end
            S_FWD: begin
                res_valid_o = 1'b1;
                res_data_o  = val_q;
            end
            S_FAULT:  align_err_o = 1'b1;
            S_SP_DEC: sp_act_o    = SP_DEC;
            S_PUSH_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_i;
                mem_wdata_o = (op_q == OP_ENTER) ? fp_i : data_q;
            end
            S_FP_SET:     fp_act_o = FP_FROM_SP;
            S_SP_SUB:     sp_act_o = SP_SUB;
            S_SP_FROM_FP: sp_act_o = SP_FROM_FP;
            S_POP_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = sp_i;
            end
            S_POP_WB: begin
                sp_act_o = SP_INC;
                if (op_q == OP_POP) begin
                    res_valid_o = 1'b1;
                    res_data_o  = mem_rdata_i;
                end else if (op_q == OP_LEAVE) begin
                    fp_act_o = FP_LOAD;
                end else begin
                    redirect_valid_o = 1'b1;
                    redirect_pc_o    = mem_rdata_i;
                end
            end
            S_REDIRECT: begin
                redirect_valid_o = 1'b1;
                redirect_pc_o    = imm_q;
            end
            default: ;
        endcase
    end

    // R6: the pushed word goes out after the pointer has dropped by one word
    p_push_after_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PUSH_WR) |-> (sp_i == $past(sp_i) - STEP));
    // R7: the pointer rises by one word after a pop write-back
    p_pop_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP_WB) |=> (sp_i == $past(sp_i) + STEP));
    // R3: load data returns one cycle after the read strobe
    p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_MEM_RDW) |-> $past(mem_req_o && !mem_we_o));
    // R8: the frame pointer holds the pushed-to stack address when the size is taken
    p_enter_fp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SP_SUB) |-> (fp_i == sp_i));
    // R10, R11: a redirect always follows a stack memory access
    p_redirect_after_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid_o |-> $past(mem_req_o));
    // R12: busy only rises when a request was present
    p_accept_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(busy_o)) |-> $past(cmd_valid_i));
    // R4: a fault returns straight to idle
    p_fault_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        align_err_o |=> !busy_o);

endmodule

// File: rtl/stack_frame_seq.sv
module stack_frame_seq
    import sfs_pkg::*;
#(
    parameter int unsigned   DW  = 32,
    parameter int unsigned   SW  = 2,
    parameter logic [DW-1:0] TOS = 32'h0000_0400
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [2:0]    cmd_mode,
    input  logic [DW-1:0] cmd_base,
    input  logic [DW-1:0] cmd_index,
    input  logic [SW-1:0] cmd_scale,
    input  logic [DW-1:0] cmd_imm,
    input  logic [DW-1:0] cmd_data,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic          redirect_valid,
    output logic [DW-1:0] redirect_pc,
    output logic          align_err,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] fp_out
);

    logic [DW-1:0] ea, operand, frame, fp_load;
    logic          is_mem, misaligned;
    sp_act_e       sp_act;
    fp_act_e       fp_act;

    sfs_agen #(.DW(DW), .SW(SW)) u_agen (
        .mode_i       (sfs_mode_e'(cmd_mode)),
        .base_i       (cmd_base),
        .index_i      (cmd_index),
        .scale_i      (cmd_scale),
        .imm_i        (cmd_imm),
        .ea_o         (ea),
        .operand_o    (operand),
        .is_mem_o     (is_mem),
        .misaligned_o (misaligned)
    );

    sfs_ctrl #(.DW(DW)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_valid_i      (cmd_valid),
        .op_i             (sfs_op_e'(cmd_op)),
        .ea_i             (ea),
        .operand_i        (operand),
        .is_mem_i         (is_mem),
        .misaligned_i     (misaligned),
        .imm_i            (cmd_imm),
        .data_i           (cmd_data),
        .sp_i             (sp_out),
        .fp_i             (fp_out),
        .mem_rdata_i      (mem_rdata),
        .busy_o           (busy),
        .mem_req_o        (mem_req),
        .mem_we_o         (mem_we),
        .mem_addr_o       (mem_addr),
        .mem_wdata_o      (mem_wdata),
        .res_valid_o      (res_valid),
        .res_data_o       (res_data),
        .redirect_valid_o (redirect_valid),
        .redirect_pc_o    (redirect_pc),
        .align_err_o      (align_err),
        .sp_act_o         (sp_act),
        .fp_act_o         (fp_act),
        .frame_o          (frame),
        .fp_load_o        (fp_load)
    );

    sfs_ptr_regs #(.DW(DW), .TOS(TOS)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sp_act_i (sp_act),
        .fp_act_i (fp_act),
        .frame_i  (frame),
        .load_i   (fp_load),
        .sp_o     (sp_out),
        .fp_o     (fp_out)
    );

    // R4: every access on the port is word aligned
    p_mem_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));
    // R4: a fault never coincides with an access
    p_fault_no_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !mem_req);

endmodule

// File: tb/test_stack_frame_seq.sv
module test_stack_frame_seq;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  mode;
        logic [1:0]  sc;
        logic [31:0] base;
        logic [31:0] idx;
        logic [31:0] imm;
        logic [31:0] dat;
        logic [31:0] e_sp;
        logic [31:0] e_fp;
        logic [1:0]  e_kind;
        logic [31:0] e_val;
    } vec_t;

    // e_kind: 0 no event, 1 result, 2 redirect, 3 alignment fault
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{3'd2, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0,        32'hAAAA0001, 32'h3FC, 32'h400, 2'd0, 32'h0},
        '{3'd2, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0,        32'hBBBB0002, 32'h3F8, 32'h400, 2'd0, 32'h0},
        '{3'd0, 3'd5, 2'd2, 32'h3F0,  32'h2,  32'h4,        32'h0,        32'h3F8, 32'h400, 2'd1, 32'hAAAA0001},
        '{3'd0, 3'd4, 2'd3, 32'h3E8,  32'h2,  32'h0,        32'h0,        32'h3F8, 32'h400, 2'd1, 32'hBBBB0002},
        '{3'd1, 3'd2, 2'd0, 32'h100,  32'h0,  32'hFFFFFFFC, 32'h12345678, 32'h3F8, 32'h400, 2'd0, 32'h0},
        '{3'd0, 3'd3, 2'd0, 32'h80,   32'h7C, 32'h0,        32'h0,        32'h3F8, 32'h400, 2'd1, 32'h12345678},
        '{3'd0, 3'd0, 2'd0, 32'hCAFE, 32'h0,  32'h0,        32'h0,        32'h3F8, 32'h400, 2'd1, 32'hCAFE},
        '{3'd0, 3'd1, 2'd0, 32'h0,    32'h0,  32'h55,       32'h0,        32'h3F8, 32'h400, 2'd1, 32'h55},
        '{3'd0, 3'd6, 2'd0, 32'h99,   32'h0,  32'h0,        32'h0,        32'h3F8, 32'h400, 2'd1, 32'h99},
        '{3'd0, 3'd5, 2'd0, 32'h101,  32'h0,  32'h0,        32'h0,        32'h3F8, 32'h400, 2'd3, 32'h0},
        '{3'd1, 3'd0, 2'd0, 32'hFC,   32'h0,  32'h0,        32'hDEAD,     32'h3F8, 32'h400, 2'd0, 32'h0},
        '{3'd0, 3'd2, 2'd0, 32'hFC,   32'h0,  32'h0,        32'h0,        32'h3F8, 32'h400, 2'd1, 32'h12345678},
        '{3'd4, 3'd0, 2'd0, 32'h0,    32'h0,  32'h10,       32'h0,        32'h3E4, 32'h3F4, 2'd0, 32'h0},
        '{3'd6, 3'd0, 2'd0, 32'h0,    32'h0,  32'h3000,     32'h2000,     32'h3E0, 32'h3F4, 2'd2, 32'h3000},
        '{3'd4, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0B,       32'h0,        32'h3D4, 32'h3DC, 2'd0, 32'h0},
        '{3'd5, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0,        32'h0,        32'h3E0, 32'h3F4, 2'd0, 32'h0},
        '{3'd7, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0,        32'h0,        32'h3E4, 32'h3F4, 2'd2, 32'h2000},
        '{3'd5, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0,        32'h0,        32'h3F8, 32'h400, 2'd0, 32'h0},
        '{3'd3, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0,        32'h0,        32'h3FC, 32'h400, 2'd1, 32'hBBBB0002},
        '{3'd3, 3'd0, 2'd0, 32'h0,    32'h0,  32'h0,        32'h0,        32'h400, 32'h400, 2'd1, 32'hAAAA0001},
        '{3'd1, 3'd5, 2'd1, 32'h102,  32'h0,  32'h0,        32'h77,       32'h400, 32'h400, 2'd3, 32'h0}
    };
    localparam string ROW_REQ [NV] = '{
        "R6", "R6", "R1", "R1", "R1", "R3", "R2", "R2", "R2", "R4", "R5",
        "R5", "R8", "R10", "R8", "R9", "R11", "R9", "R7", "R7", "R4"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0, cmd_mode = '0;
    logic [31:0] cmd_base = '0, cmd_index = '0, cmd_imm = '0, cmd_data = '0;
    logic [1:0]  cmd_scale = '0;
    logic        busy, mem_req, mem_we, res_valid, redirect_valid, align_err;
    logic [31:0] mem_addr, mem_wdata, res_data, redirect_pc, sp_out, fp_out;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem [0:511];

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    stack_frame_seq i_stack_frame_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_index(cmd_index),
        .cmd_scale(cmd_scale), .cmd_imm(cmd_imm), .cmd_data(cmd_data),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .res_valid(res_valid),
        .res_data(res_data), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .align_err(align_err),
        .sp_out(sp_out), .fp_out(fp_out)
    );

    // word memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:2]];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sample(inout logic [1:0] kind, inout logic [31:0] val);
        if (res_valid)      begin kind = 2'd1; val = res_data;    end
        if (redirect_valid) begin kind = 2'd2; val = redirect_pc; end
        if (align_err)      begin kind = 2'd3; val = 32'h0;       end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [2:0] mode, input logic [1:0] sc,
                           input logic [31:0] base, input logic [31:0] idx,
                           input logic [31:0] imm, input logic [31:0] dat,
                           output logic [1:0] kind, output logic [31:0] val);
        @(negedge clk);
        cmd_op = op; cmd_mode = mode; cmd_scale = sc; cmd_base = base;
        cmd_index = idx; cmd_imm = imm; cmd_data = dat; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        kind = 2'd0; val = 32'h0;
        sample(kind, val);
        for (int g = 0; g < 50 && busy; g++) begin
            @(negedge clk);
            sample(kind, val);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL R12 watchdog expired actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [1:0]  kind;
        logic [31:0] val;
        for (int i = 0; i < 512; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 sp after reset", sp_out, 32'h400);
        check("R13 fp after reset", fp_out, 32'h400);
        check("R13 busy after reset", {31'h0, busy}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_cmd(VEC[i].op, VEC[i].mode, VEC[i].sc, VEC[i].base, VEC[i].idx,
                    VEC[i].imm, VEC[i].dat, kind, val);
            check({ROW_REQ[i], " sp row ", $sformatf("%0d", i)}, sp_out, VEC[i].e_sp);
            check({ROW_REQ[i], " fp row ", $sformatf("%0d", i)}, fp_out, VEC[i].e_fp);
            check({ROW_REQ[i], " event row ", $sformatf("%0d", i)}, {30'h0, kind}, {30'h0, VEC[i].e_kind});
            check({ROW_REQ[i], " value row ", $sformatf("%0d", i)}, val, VEC[i].e_val);
        end

        // R12: request during the last busy cycle of an enter is dropped
        @(negedge clk);
        cmd_op = 3'd4; cmd_mode = 3'd0; cmd_imm = 32'h8; cmd_valid = 1'b1;
        @(negedge clk);               // state: lower sp
        cmd_valid = 1'b0;
        @(negedge clk);               // state: write old fp
        @(negedge clk);               // state: copy sp to fp
        @(negedge clk);               // state: subtract size (last busy cycle)
        check("R12 busy in last enter step", {31'h0, busy}, 32'h1);
        cmd_op = 3'd2; cmd_data = 32'h5555; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R12 dropped request leaves idle", {31'h0, busy}, 32'h0);
        check("R12 sp after enter only", sp_out, 32'h3F4);
        check("R8 fp after enter", fp_out, 32'h3FC);

        // R12: pop requested while a push is busy is dropped
        @(negedge clk);
        cmd_op = 3'd2; cmd_data = 32'h77; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_op = 3'd3;                // still high during busy
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 sp after push with held pop", sp_out, 32'h3F0);
        run_cmd(3'd3, 3'd0, 2'd0, 0, 0, 0, 0, kind, val);
        check("R7 pop returns pushed word", val, 32'h77);
        check("R7 sp after pop", sp_out, 32'h3F4);
        run_cmd(3'd5, 3'd0, 2'd0, 0, 0, 0, 0, kind, val);
        check("R9 fp restored by leave", fp_out, 32'h400);
        check("R9 sp after leave", sp_out, 32'h400);

        // R13: reset in the middle of an enter
        @(negedge clk);
        cmd_op = 3'd4; cmd_imm = 32'h20; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 sp after mid-command reset", sp_out, 32'h400);
        check("R13 fp after mid-command reset", fp_out, 32'h400);
        check("R13 busy after mid-command reset", {31'h0, busy}, 32'h0);

        // R9: frame pointer loaded by leave has its low bits cleared
        run_cmd(3'd1, 3'd2, 2'd0, 32'h400, 0, 0, 32'h333, kind, val);
        run_cmd(3'd5, 3'd0, 2'd0, 0, 0, 0, 0, kind, val);
        check("R9 masked fp", fp_out, 32'h330);
        check("R9 sp after leave at top", sp_out, 32'h404);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule